// File: doc/BRIEF.md
# Block Write Acceptance Checker

This block sits on the card side of a memory-card data path. It decides, block by block, whether data sent by the host in a write command is stored or thrown away. A start strobe opens a transfer. The strobe carries a byte address and a flag that selects single-block or multiple-block mode, or it selects programming of the identification or configuration register. Before each block the block checks that the block address fits the native block size and is not in a protected area. The protection answer comes from an external lookup driven by the block's own `blk_addr` output. Received bytes arrive already deserialised. The final byte of a block arrives together with an end marker and the verdict of an external CRC checker.

For each block the block returns a three-bit status token, a commit or discard pulse, and a busy window. Four sticky error flags stay set until a status read clears them. In register-programming mode the received word is compared against a fixed ROM portion under a mask. The internal register is then either replaced as a whole or left exactly as it was.

Top module: `blkwr_rx`

## Requirements
- R1: A data block whose end marker comes with CRC good and whose byte count equals `blk_len` is accepted. One cycle after its last byte is taken, `tok_valid` and `commit` pulse together with `tok` = 3'b010, and `busy` is then high for exactly BUSY_CYC cycles.
- R2: A block that ends with CRC bad, or whose byte count differs from the expected length, is rejected. `tok_valid` and `discard` pulse with `tok` = 3'b101, `err_crc` sets in the same cycle, and no `commit` occurs.
- R3: After a rejected block in multiple-block mode, later blocks of the same transfer produce no token, commit or discard until a new start.
- R4: In multiple-block mode `blk_addr` starts at `start_addr` and advances by `blk_len` after each committed block. Every block is checked again before it starts. A `stop` pulse ends the transfer after the current block's busy window, and data sent after that is not committed.
- R5: With `misalign_ok` = 0, a block is refused before any of its data is taken when (`blk_addr` mod NATIVE_LEN) + `blk_len` > NATIVE_LEN. `err_addr` is set, and that block and all later ones in the transfer are not committed. With `misalign_ok` = 1 the same block is accepted.
- R6: A block whose address check finds `wp_hit` = 1 is refused the same way, but sets `err_wp` and leaves `err_addr` clear. A block that is both misaligned (with `misalign_ok` = 0) and protected sets only `err_addr`.
- R7: In register mode (`start_reg` = 1) exactly REG_W/8 bytes are expected, first byte most significant. This mode ignores `blk_len`, the address check and `wp_hit`. With CRC good and all ROM bits matching, `reg_data` takes the received word and `commit` pulses with `tok` = 3'b010.
- R8: In register mode, if any bit where `rom_mask` is 1 differs from `rom_ref`, `err_rom` sets, `discard` pulses with `tok` = 3'b010, and `reg_data` is unchanged. A CRC failure in this mode also leaves `reg_data` unchanged.
- R9: `err_crc`, `err_addr`, `err_wp` and `err_rom` stay set until a `status_rd` pulse clears all four.
- R10: After reset, all pulse outputs, `busy` and all error flags are 0, `tok` is 3'b000 and `reg_data` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new transfer (restarts any ongoing one) |
| start_addr | input | ADDR_W | Byte address of the first block |
| start_multi | input | 1 | 1 = multiple-block transfer |
| start_reg | input | 1 | 1 = identification/configuration register programming |
| blk_len | input | LEN_W | Configured block length in bytes |
| misalign_ok | input | 1 | 1 = blocks may cross a native block boundary |
| blk_addr | output | ADDR_W | Address of the current block, for the protection lookup |
| wp_hit | input | 1 | Protection lookup result for `blk_addr` |
| data_valid | input | 1 | A received byte is present |
| data_byte | input | 8 | Received byte |
| blk_end | input | 1 | With `data_valid`: this byte is the last of the block |
| crc_good | input | 1 | With `blk_end`: the block CRC matched |
| stop | input | 1 | Ends a multiple-block transfer after the current block |
| rom_mask | input | REG_W | 1 marks a ROM (fixed) bit of the register |
| rom_ref | input | REG_W | Fixed values of the ROM bits |
| status_rd | input | 1 | Clears all error flags |
| commit | output | 1 | Pulse: block or register write accepted |
| discard | output | 1 | Pulse: block or register write thrown away |
| tok_valid | output | 1 | Pulse: `tok` carries a new token |
| tok | output | 3 | Status token, 010 accepted, 101 CRC error |
| busy | output | 1 | Programming busy window after a commit |
| err_crc | output | 1 | Sticky CRC / length error |
| err_addr | output | 1 | Sticky misalignment error |
| err_wp | output | 1 | Sticky protection violation |
| err_rom | output | 1 | Sticky ROM-portion mismatch |
| reg_data | output | REG_W | Current register content |

## Verification
The alignment rule is swept over every block length from 1 to NATIVE_LEN against every start offset inside a native block. This separates blocks that just fit from blocks that cross the boundary by a single byte, and one crossing case is repeated with misalignment allowed. Multiple-block runs use lengths that divide the native size and lengths that do not, so that the address advance, the check before each block and stop handling can be told apart from a check done only at the start. CRC failures and short or long blocks are injected in the middle of a transfer to show that the following blocks are poisoned. Protected regions are reached both by a first block and by a later block, including one address that is also misaligned, to show which flag wins. Register programming is tried with a matching word, a word that differs only in ROM bits, and a matching word with a bad CRC, using block settings that would otherwise be refused.

// File: rtl/blkwr_pkg.sv
// Shared types for the block write acceptance checker.
// Assumes: tokens are three bits wide and consumed by a serializer elsewhere.
package blkwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_RECV,
        ST_BUSY,
        ST_HALT
    } blk_state_e;

    localparam logic [2:0] TOK_ACK = 3'b010;
    localparam logic [2:0] TOK_NAK = 3'b101;

    typedef struct packed {
        logic rom;
        logic wp;
        logic addr;
        logic crc;
    } err_set_t;

endpackage

// File: rtl/blkwr_align.sv
// Boundary test for a block about to start.
// Flags a block whose offset inside a native block plus its length
// runs past the native block end. Assumes NATIVE_LEN is a power of two
// and LEN_W >= OFF_W.
module blkwr_align #(
    parameter int NATIVE_LEN = 16,
    parameter int LEN_W      = 8,
    localparam int OFF_W     = $clog2(NATIVE_LEN)
) (
    input  logic [OFF_W-1:0] blk_off,
    input  logic [LEN_W-1:0] blk_len,
    output logic             misaligned
);

    logic [LEN_W:0] span_end;

    // Purpose: end of the block measured from the native block start.
    always_comb begin
        span_end   = (LEN_W+1)'(blk_off) + (LEN_W+1)'(blk_len);
        misaligned = span_end > (LEN_W+1)'(NATIVE_LEN);
    end

endmodule

// File: rtl/blkwr_regprog.sv
// Register programming store with a ROM-portion guard.
// Bytes shift in first-byte-most-significant. The word formed with the
// current byte is compared under the mask, and the store loads only
// when the controller says so. Assumes REG_W is a multiple of 8, >= 16.
module blkwr_regprog #(
    parameter int REG_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic [7:0]       data_byte,
    input  logic             load,
    input  logic [REG_W-1:0] rom_mask,
    input  logic [REG_W-1:0] rom_ref,
    output logic             rom_ok,
    output logic [REG_W-1:0] reg_q
);

    logic [REG_W-9:0] shreg;
    logic [REG_W-1:0] word_next;

    // Purpose: assemble the candidate word and test its fixed bits.
    always_comb begin
        word_next = {shreg, data_byte};
        rom_ok    = ((word_next ^ rom_ref) & rom_mask) == '0;
    end

    // Purpose: keep the shift history and the committed register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg <= '0;
            reg_q <= '0;
        end else begin
            if (shift_en) shreg <= word_next[REG_W-9:0];
            if (load)     reg_q <= word_next;
        end
    end

endmodule

// File: rtl/blkwr_status.sv
// Sticky error flags. A set pulse wins over a clear in the same cycle.
// Assumes set pulses last one cycle and come from the controller.
module blkwr_status #(
    parameter int NBITS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NBITS-1:0] set,
    input  logic             clr,
    output logic [NBITS-1:0] flags
);

    for (genvar i = 0; i < NBITS; i++) begin : g_flag
        // Purpose: hold one flag until cleared.
        always_ff @(posedge clk) begin
            if (!rst_n)      flags[i] <= 1'b0;
            else if (set[i]) flags[i] <= 1'b1;
            else if (clr)    flags[i] <= 1'b0;
        end
    end

endmodule

// File: rtl/blkwr_ctrl.sv
// Transfer sequencer: pre-block checks, byte counting, verdicts, busy.
// Assumes the host waits for busy to drop before the next block, and that
// blk_end and crc_good are only meaningful together with data_valid.
module blkwr_ctrl
    import blkwr_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int LEN_W    = 8,
    parameter int REG_W    = 32,
    parameter int BUSY_CYC = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_multi,
    input  logic              start_reg,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              misalign_ok,
    input  logic              misaligned,
    input  logic              wp_hit,
    input  logic              data_valid,
    input  logic              blk_end,
    input  logic              crc_good,
    input  logic              stop,
    input  logic              rom_ok,
    output logic [ADDR_W-1:0] blk_addr,
    output logic              commit,
    output logic              discard,
    output logic              tok_valid,
    output logic [2:0]        tok,
    output logic              busy,
    output err_set_t          err_set,
    output logic              reg_load,
    output logic              reg_shift
);

    localparam int REG_BYTES = REG_W / 8;
    localparam int RB_W      = $clog2(REG_BYTES + 1);
    localparam int CNT_W     = ((RB_W > LEN_W) ? RB_W : LEN_W) + 1;
    localparam int BCNT_W    = $clog2(BUSY_CYC + 1);

    blk_state_e        state, nxt;
    logic [ADDR_W-1:0] addr_n;
    logic              multi_q, multi_n, regm_q, regm_n, stop_q, stop_n;
    logic [CNT_W-1:0]  cnt_q, cnt_n, cnt_inc, exp_len;
    logic [BCNT_W-1:0] bcnt_q, bcnt_n;
    logic              commit_n, discard_n, tokv_n, busy_n;
    logic [2:0]        tok_n;

    // Purpose: next-state, verdict and event decode for one cycle.
    always_comb begin
        nxt       = state;
        addr_n    = blk_addr;
        multi_n   = multi_q;
        regm_n    = regm_q;
        stop_n    = stop_q;
        cnt_n     = cnt_q;
        bcnt_n    = bcnt_q;
        commit_n  = 1'b0;
        discard_n = 1'b0;
        tokv_n    = 1'b0;
        tok_n     = tok;
        err_set   = '0;
        reg_load  = 1'b0;
        cnt_inc   = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;
        exp_len   = regm_q ? CNT_W'(REG_BYTES) : CNT_W'(blk_len);
        if (start) begin
            addr_n  = start_addr;
            multi_n = start_multi;
            regm_n  = start_reg;
            stop_n  = 1'b0;
            cnt_n   = '0;
            nxt     = start_reg ? ST_RECV : ST_CHECK;
        end else begin
            case (state)
                ST_CHECK: begin
                    if (stop) begin
                        nxt = ST_IDLE;
                    end else if (misaligned && !misalign_ok) begin
                        err_set.addr = 1'b1;
                        nxt          = ST_HALT;
                    end else if (wp_hit) begin
                        err_set.wp = 1'b1;
                        nxt        = ST_HALT;
                    end else begin
                        cnt_n = '0;
                        nxt   = ST_RECV;
                    end
                end
                ST_RECV: begin
                    if (stop) stop_n = 1'b1;
                    if (data_valid && blk_end) begin
                        cnt_n  = '0;
                        tokv_n = 1'b1;
                        bcnt_n = BCNT_W'(BUSY_CYC - 1);
                        if (!crc_good || cnt_inc != exp_len) begin
                            tok_n       = TOK_NAK;
                            discard_n   = 1'b1;
                            err_set.crc = 1'b1;
                            nxt         = (multi_q && !regm_q) ? ST_HALT : ST_IDLE;
                        end else if (regm_q) begin
                            tok_n = TOK_ACK;
                            if (rom_ok) begin
                                reg_load = 1'b1;
                                commit_n = 1'b1;
                                nxt      = ST_BUSY;
                            end else begin
                                discard_n   = 1'b1;
                                err_set.rom = 1'b1;
                                nxt         = ST_IDLE;
                            end
                        end else begin
                            tok_n    = TOK_ACK;
                            commit_n = 1'b1;
                            addr_n   = blk_addr + ADDR_W'(blk_len);
                            nxt      = ST_BUSY;
                        end
                    end else if (data_valid) begin
                        cnt_n = cnt_inc;
                    end
                end
                ST_BUSY: begin
                    if (stop) stop_n = 1'b1;
                    if (bcnt_q == '0)
                        nxt = (multi_q && !regm_q && !stop_n) ? ST_CHECK : ST_IDLE;
                    else
                        bcnt_n = bcnt_q - 1'b1;
                end
                ST_HALT: begin
                    if (stop) nxt = ST_IDLE;
                end
                default: nxt = ST_IDLE;
            endcase
        end
        busy_n    = (nxt == ST_BUSY);
        reg_shift = !start && state == ST_RECV && regm_q && data_valid;
    end

    // Purpose: register state and all outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            blk_addr  <= '0;
            multi_q   <= 1'b0;
            regm_q    <= 1'b0;
            stop_q    <= 1'b0;
            cnt_q     <= '0;
            bcnt_q    <= '0;
            commit    <= 1'b0;
            discard   <= 1'b0;
            tok_valid <= 1'b0;
            tok       <= 3'b000;
            busy      <= 1'b0;
        end else begin
            state     <= nxt;
            blk_addr  <= addr_n;
            multi_q   <= multi_n;
            regm_q    <= regm_n;
            stop_q    <= stop_n;
            cnt_q     <= cnt_n;
            bcnt_q    <= bcnt_n;
            commit    <= commit_n;
            discard   <= discard_n;
            tok_valid <= tokv_n;
            tok       <= tok_n;
            busy      <= busy_n;
        end
    end

endmodule

// File: rtl/blkwr_rx.sv
// Top of the block write acceptance checker.
// Wires the sequencer, boundary test, register store and sticky flags.
// Assumes external CRC checking and an external protection lookup that
// answers combinationally for blk_addr.
module blkwr_rx
    import blkwr_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int LEN_W      = 8,
    parameter int NATIVE_LEN = 16,
    parameter int REG_W      = 32,
    parameter int BUSY_CYC   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              start_multi,
    input  logic              start_reg,
    input  logic [LEN_W-1:0]  blk_len,
    input  logic              misalign_ok,
    output logic [ADDR_W-1:0] blk_addr,
    input  logic              wp_hit,
    input  logic              data_valid,
    input  logic [7:0]        data_byte,
    input  logic              blk_end,
    input  logic              crc_good,
    input  logic              stop,
    input  logic [REG_W-1:0]  rom_mask,
    input  logic [REG_W-1:0]  rom_ref,
    input  logic              status_rd,
    output logic              commit,
    output logic              discard,
    output logic              tok_valid,
    output logic [2:0]        tok,
    output logic              busy,
    output logic              err_crc,
    output logic              err_addr,
    output logic              err_wp,
    output logic              err_rom,
    output logic [REG_W-1:0]  reg_data
);

    localparam int OFF_W = $clog2(NATIVE_LEN);

    logic     misaligned, rom_ok, reg_load, reg_shift;
    err_set_t err_set;
    logic [3:0] flags;

    blkwr_ctrl #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .REG_W(REG_W), .BUSY_CYC(BUSY_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_multi(start_multi), .start_reg(start_reg), .blk_len(blk_len),
        .misalign_ok(misalign_ok), .misaligned(misaligned), .wp_hit(wp_hit),
        .data_valid(data_valid), .blk_end(blk_end), .crc_good(crc_good),
        .stop(stop), .rom_ok(rom_ok), .blk_addr(blk_addr), .commit(commit),
        .discard(discard), .tok_valid(tok_valid), .tok(tok), .busy(busy),
        .err_set(err_set), .reg_load(reg_load), .reg_shift(reg_shift)
    );

    blkwr_align #(
        .NATIVE_LEN(NATIVE_LEN), .LEN_W(LEN_W)
    ) u_align (
        .blk_off(blk_addr[OFF_W-1:0]), .blk_len(blk_len), .misaligned(misaligned)
    );

    blkwr_regprog #(
        .REG_W(REG_W)
    ) u_regprog (
        .clk(clk), .rst_n(rst_n), .shift_en(reg_shift), .data_byte(data_byte),
        .load(reg_load), .rom_mask(rom_mask), .rom_ref(rom_ref),
        .rom_ok(rom_ok), .reg_q(reg_data)
    );

    blkwr_status #(
        .NBITS(4)
    ) u_status (
        .clk(clk), .rst_n(rst_n), .set(err_set), .clr(status_rd), .flags(flags)
    );

    assign err_crc  = flags[0];
    assign err_addr = flags[1];
    assign err_wp   = flags[2];
    assign err_rom  = flags[3];

endmodule

// File: rtl/blkwr_rx_chk.sv
// Property checker for blkwr_rx, attached through bind.
// Assumes reset is asserted from time zero.
module blkwr_rx_chk #(
    parameter int REG_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             commit,
    input logic             discard,
    input logic             tok_valid,
    input logic [2:0]       tok,
    input logic             busy,
    input logic             err_crc,
    input logic             err_addr,
    input logic             err_wp,
    input logic             err_rom,
    input logic             status_rd,
    input logic [REG_W-1:0] reg_data
);

    assert_commit_ack_R1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (tok_valid && tok == 3'b010));

    assert_commit_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> busy);

    assert_tok_legal_R1: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid |-> (tok == 3'b010 || tok == 3'b101));

    assert_nak_flags_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_valid && tok == 3'b101) |-> (err_crc && discard));

    assert_single_verdict_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(commit && discard));

    assert_reg_change_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(reg_data) |-> commit);

    assert_sticky_crc_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_crc && !status_rd) |=> err_crc);

    assert_sticky_addr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_addr && !status_rd) |=> err_addr);

    assert_sticky_wp_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_wp && !status_rd) |=> err_wp);

    assert_sticky_rom_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (err_rom && !status_rd) |=> err_rom);

endmodule

bind blkwr_rx blkwr_rx_chk #(.REG_W(REG_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .commit(commit), .discard(discard),
    .tok_valid(tok_valid), .tok(tok), .busy(busy), .err_crc(err_crc),
    .err_addr(err_addr), .err_wp(err_wp), .err_rom(err_rom),
    .status_rd(status_rd), .reg_data(reg_data)
);

// File: tb/blkwr_rx_bench.sv
`timescale 1ns/1ps
module blkwr_rx_bench;

    localparam int ADDR_W = 16, LEN_W = 8, NATIVE = 16, REG_W = 32, BUSY_CYC = 3;

    logic clk = 1'b0, rst_n = 1'b0;
    logic start = 0, start_multi = 0, start_reg = 0, misalign_ok = 0;
    logic [ADDR_W-1:0] start_addr = '0;
    logic [LEN_W-1:0] blk_len = 8'd4;
    logic [ADDR_W-1:0] blk_addr;
    logic wp_hit;
    logic data_valid = 0, blk_end = 0, crc_good = 0, stop = 0, status_rd = 0;
    logic [7:0] data_byte = '0;
    logic [REG_W-1:0] rom_mask = 32'hFF00_0000, rom_ref = 32'hA500_0000;
    logic commit, discard, tok_valid, busy, err_crc, err_addr, err_wp, err_rom;
    logic [2:0] tok;
    logic [REG_W-1:0] reg_data;

    int n_chk = 0, n_fail = 0, n_commit = 0, n_disc = 0, n_tok = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    // protected window 0x20..0x2F
    assign wp_hit = (blk_addr >= 16'h0020) && (blk_addr < 16'h0030);

    blkwr_rx #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .NATIVE_LEN(NATIVE),
               .REG_W(REG_W), .BUSY_CYC(BUSY_CYC)) u_blkwr_rx (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_multi(start_multi), .start_reg(start_reg), .blk_len(blk_len),
        .misalign_ok(misalign_ok), .blk_addr(blk_addr), .wp_hit(wp_hit),
        .data_valid(data_valid), .data_byte(data_byte), .blk_end(blk_end),
        .crc_good(crc_good), .stop(stop), .rom_mask(rom_mask), .rom_ref(rom_ref),
        .status_rd(status_rd), .commit(commit), .discard(discard),
        .tok_valid(tok_valid), .tok(tok), .busy(busy), .err_crc(err_crc),
        .err_addr(err_addr), .err_wp(err_wp), .err_rom(err_rom), .reg_data(reg_data)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (commit)    n_commit++;
            if (discard)   n_disc++;
            if (tok_valid) n_tok++;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic begin_xfer(input logic [ADDR_W-1:0] a, input bit multi, input bit regm);
        start_addr = a; start_multi = multi; start_reg = regm; start = 1;
        @(negedge clk); start = 0;
        @(negedge clk);
    endtask

    task automatic send_block(input int n, input bit good);
        for (int i = 0; i < n; i++) begin
            data_valid = 1; data_byte = 8'(i + 1);
            blk_end = (i == n - 1); crc_good = good;
            @(negedge clk);
        end
        data_valid = 0; blk_end = 0; crc_good = 0;
    endtask

    task automatic send_word(input logic [31:0] w, input bit good);
        for (int i = 0; i < 4; i++) begin
            data_valid = 1; data_byte = w[31-8*i -: 8];
            blk_end = (i == 3); crc_good = good;
            @(negedge clk);
        end
        data_valid = 0; blk_end = 0; crc_good = 0;
    endtask

    task automatic settle();
        repeat (BUSY_CYC + 3) @(negedge clk);
    endtask

    task automatic clear_status();
        status_rd = 1; @(negedge clk); status_rd = 0;
    endtask

    task automatic do_stop();
        stop = 1; @(negedge clk); stop = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int c0, d0, t0;
        logic [31:0] saved;
        repeat (4) @(negedge clk);
        // R10 reset state
        chk({commit, discard, tok_valid, busy, err_crc, err_addr, err_wp, err_rom} == 8'h00,
            "R10 outputs after reset", {commit, discard, tok_valid, busy, err_crc, err_addr, err_wp, err_rom}, 0);
        chk(tok == 3'b000 && reg_data == 0, "R10 tok/reg_data after reset", {tok, reg_data[27:0]}, 0);
        rst_n = 1;
        @(negedge clk);

        // R1 single good block, token and busy window
        blk_len = 4; c0 = n_commit;
        begin_xfer(16'h0040, 0, 0);
        send_block(4, 1);
        chk(commit && tok_valid && tok == 3'b010, "R1 commit+ack after last byte", {commit, tok_valid, tok}, 5'b11010);
        chk(busy == 1, "R1 busy starts with commit", busy, 1);
        repeat (BUSY_CYC - 1) @(negedge clk);
        chk(busy == 1, "R1 busy in last busy cycle", busy, 1);
        @(negedge clk);
        chk(busy == 0, "R1 busy ends after BUSY_CYC", busy, 0);
        settle();
        chk(n_commit == c0 + 1, "R1 one commit", n_commit, c0 + 1);

        // R5 exhaustive alignment sweep
        for (int len = 1; len <= NATIVE; len++) begin
            for (int off = 0; off < NATIVE; off++) begin
                bit exp_bad;
                exp_bad = (off + len) > NATIVE;
                blk_len = 8'(len); c0 = n_commit;
                clear_status();
                begin_xfer(16'(16'h0040 + off), 0, 0);
                chk(err_addr == exp_bad, $sformatf("R5 err_addr len=%0d off=%0d", len, off), err_addr, exp_bad);
                send_block(len, 1);
                settle();
                chk(n_commit == c0 + (exp_bad ? 0 : 1), $sformatf("R5 commit len=%0d off=%0d", len, off),
                    n_commit - c0, exp_bad ? 0 : 1);
            end
        end
        // R5 misalignment allowed
        misalign_ok = 1; blk_len = 8; c0 = n_commit; clear_status();
        begin_xfer(16'h004C, 0, 0);
        send_block(8, 1); settle();
        chk(err_addr == 0 && n_commit == c0 + 1, "R5 misalign_ok accepts crossing block", {err_addr, 8'(n_commit - c0)}, 1);
        misalign_ok = 0;

        // R4 multi-block with stop
        blk_len = 4; c0 = n_commit; clear_status();
        begin_xfer(16'h0000, 1, 0);
        for (int b = 0; b < 4; b++) begin
            send_block(4, 1);
            if (b == 3) do_stop();
            settle();
        end
        chk(n_commit == c0 + 4, "R4 four blocks committed", n_commit - c0, 4);
        chk(blk_addr == 16'd16, "R4 address advanced by blk_len", blk_addr, 16);
        c0 = n_commit;
        send_block(4, 1); settle();
        chk(n_commit == c0, "R4 data after stop not committed", n_commit - c0, 0);

        // R4/R5 later block misaligned
        blk_len = 6; c0 = n_commit; clear_status();
        begin_xfer(16'h0000, 1, 0);
        send_block(6, 1); settle();
        send_block(6, 1); settle();
        chk(n_commit == c0 + 2 && err_addr == 1, "R4 third block at 12 refused", {err_addr, 8'(n_commit - c0)}, 9'h102);
        send_block(6, 1); settle();
        chk(n_commit == c0 + 2, "R5 refused block not committed", n_commit - c0, 2);
        do_stop();

        // R2/R3 CRC failure mid-transfer poisons the rest
        blk_len = 4; c0 = n_commit; d0 = n_disc; clear_status();
        begin_xfer(16'h0000, 1, 0);
        send_block(4, 1); settle();
        send_block(4, 0);
        chk(discard && tok_valid && tok == 3'b101 && err_crc, "R2 nak on bad crc", {discard, tok_valid, tok, err_crc}, 6'b111011);
        settle();
        t0 = n_tok;
        send_block(4, 1); settle();
        send_block(4, 1); settle();
        chk(n_tok == t0 && n_commit == c0 + 1 && n_disc == d0 + 1, "R3 later blocks ignored",
            {8'(n_tok - t0), 8'(n_commit - c0), 8'(n_disc - d0)}, 24'h000101);
        do_stop();

        // R2 short and long blocks
        clear_status(); c0 = n_commit;
        begin_xfer(16'h0000, 0, 0);
        send_block(3, 1); settle();
        chk(err_crc && tok == 3'b101 && n_commit == c0, "R2 short block rejected", {err_crc, tok}, 4'b1101);
        clear_status();
        begin_xfer(16'h0000, 0, 0);
        send_block(5, 1); settle();
        chk(err_crc && tok == 3'b101 && n_commit == c0, "R2 long block rejected", {err_crc, tok}, 4'b1101);

        // R6 protection
        blk_len = 8; clear_status(); c0 = n_commit;
        begin_xfer(16'h0020, 0, 0);
        chk(err_wp == 1 && err_addr == 0, "R6 protected first block", {err_wp, err_addr}, 2'b10);
        send_block(8, 1); settle();
        chk(n_commit == c0, "R6 protected block not committed", n_commit - c0, 0);
        clear_status();
        begin_xfer(16'h0010, 1, 0);
        send_block(8, 1); settle();
        send_block(8, 1); settle();
        chk(n_commit == c0 + 2 && err_wp == 1 && err_addr == 0, "R6 later block hits protected area",
            {err_wp, err_addr, 8'(n_commit - c0)}, 10'h202);
        do_stop();
        clear_status();
        begin_xfer(16'h002C, 0, 0);
        chk(err_addr == 1 && err_wp == 0, "R6 misalign wins over protection", {err_addr, err_wp}, 2'b10);

        // R9 clear
        clear_status();
        chk({err_crc, err_addr, err_wp, err_rom} == 0, "R9 status_rd clears flags", {err_crc, err_addr, err_wp, err_rom}, 0);
        begin_xfer(16'h002C, 0, 0);
        repeat (5) @(negedge clk);
        chk(err_addr == 1, "R9 flag held without status read", err_addr, 1);

        // R7 register programming ignores length/alignment/protection
        blk_len = 3; clear_status(); c0 = n_commit;
        begin_xfer(16'h002F, 0, 1);
        send_word(32'hA512_3456, 1);
        chk(commit && tok == 3'b010, "R7 register commit ack", {commit, tok}, 4'b1010);
        settle();
        chk(reg_data == 32'hA512_3456 && err_addr == 0 && err_wp == 0, "R7 register written", reg_data, 32'hA512_3456);
        // R8 ROM mismatch
        d0 = n_disc; saved = reg_data;
        begin_xfer(16'h0000, 0, 1);
        send_word(32'h5A00_0001, 1); settle();
        chk(err_rom && tok == 3'b010 && n_disc == d0 + 1, "R8 rom mismatch flagged", {err_rom, tok}, 4'b1010);
        chk(reg_data == saved, "R8 register unchanged on mismatch", reg_data, saved);
        // R8 CRC bad in register mode
        begin_xfer(16'h0000, 0, 1);
        send_word(32'hA5FF_FFFF, 0); settle();
        chk(err_crc && tok == 3'b101 && reg_data == saved, "R8 register unchanged on bad crc", reg_data, saved);

        summary();
    end

endmodule